// File: doc/BRIEF.md
# Periodic Interval Timer

A memory-mapped timer that produces a steady stream of period events from the system clock. A fixed divide-by-16 prescaler drives a 20-bit interval counter. The counter runs from zero up to a programmed limit and then returns to zero. Each return to zero sets a pending flag and adds one to a 12-bit count of periods that have elapsed since the last acknowledge. A level interrupt is raised while the flag is pending and the interrupt is enabled.

Software keeps time by combining the elapsed-period count with the live counter word. Two read paths return that pair. One read acknowledges: it clears the pending flag and the period count. The other read is a snapshot with no side effects. The interrupt can be masked while counting continues. When the timer is disabled, it does not stop at once: it finishes the period in progress and then rests at zero.

Top module: `pit_timer`

## Requirements
- R1: After reset, every register reads zero, `irq_o` is low and the counter stays at zero.
- R2: A write to offset 0x0 sets the mode word. Bits 19:0 hold the limit value, bit 24 enables counting and bit 25 enables the interrupt. A read of offset 0x0 returns those fields, with all other bits zero.
- R3: While running, the counter advances by one on every 16th clock cycle. The first advance comes 16 cycles after counting is enabled from rest.
- R4: A period lasts limit+1 prescaled ticks. On the tick where the counter equals the limit, the counter returns to 0, the period count increments and the pending flag (status bit 0) sets.
- R5: A read of offset 0x8 returns the period count in bits 31:20 and the counter in bits 19:0. The same read clears the pending flag and the period count. If a period ends in that same cycle, the period count becomes 1 and the flag stays set.
- R6: A read of offset 0xC returns the same layout as offset 0x8 and changes neither the flag nor the period count.
- R7: A read of offset 0x4 returns the pending flag in bit 0, with all other bits zero, and has no side effect.
- R8: `irq_o` is high exactly when the pending flag is set and the interrupt enable is set. Clearing the interrupt enable does not stop counting.
- R9: After counting is disabled, the counter runs on to the end of the current period, including the flag and count update there, and then holds at zero.
- R10: The period count wraps modulo 4096.
- R11: Writes to offsets 0x4, 0x8 and 0xC have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access in this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of the read |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that each bus access lasts a single cycle. They also assume that the limit is reprogrammed only when the new value is not below the counter: a lower limit would run the counter past it until the 20-bit value wraps. The stimulus changes the limit only from rest, or with a value at or above the current counter. It drives every access for exactly one clock. Acknowledging reads are issued on every cycle across whole periods, so that an acknowledge lands on the same edge as a period end.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int PIV_W   = 20;
  localparam int CNT_W   = 12;
  localparam int PRE_W   = 4;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;
  localparam int EN_BIT  = 24;
  localparam int IEN_BIT = 25;
  localparam logic [ADDR_W-1:0] OFS_MODE = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_VAL  = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_IMG  = 4'hC;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i & (&cnt_q);
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int PIV_W = 20,
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ack_i,
  input  logic [PIV_W-1:0] piv_i,
  output logic [PIV_W-1:0] cpiv_o,
  output logic [CNT_W-1:0] picnt_o,
  output logic             sts_o
);
  logic [PIV_W-1:0] cpiv_q;
  logic [CNT_W-1:0] picnt_q;
  logic             sts_q;
  logic             wrap;

  assign wrap = tick_i && (cpiv_q == piv_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpiv_q  <= '0;
      picnt_q <= '0;
      sts_q   <= 1'b0;
    end else begin
      if (tick_i) cpiv_q <= wrap ? '0 : cpiv_q + 1'b1;
      // period end beats a same-cycle acknowledge
      if (wrap) begin
        picnt_q <= ack_i ? CNT_W'(1) : picnt_q + 1'b1;
        sts_q   <= 1'b1;
      end else if (ack_i) begin
        picnt_q <= '0;
        sts_q   <= 1'b0;
      end
    end
  end

  assign cpiv_o  = cpiv_q;
  assign picnt_o = picnt_q;
  assign sts_o   = sts_q;
endmodule

// File: rtl/pit_bus_regs.sv
module pit_bus_regs
  import pit_pkg::*;
#(
  parameter int PIV_W  = pit_pkg::PIV_W,
  parameter int CNT_W  = pit_pkg::CNT_W,
  parameter int DATA_W = pit_pkg::DATA_W,
  parameter int ADDR_W = pit_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PIV_W-1:0]  cpiv_i,
  input  logic [CNT_W-1:0]  picnt_i,
  input  logic              sts_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [PIV_W-1:0]  piv_o,
  output logic              en_o,
  output logic              ien_o,
  output logic              ack_o
);
  logic [PIV_W-1:0] piv_q;
  logic             en_q, ien_q;
  logic             wr_mode;
  logic             unused_wdata;

  assign wr_mode      = req_i && we_i && (addr_i == OFS_MODE);
  assign ack_o        = req_i && !we_i && (addr_i == OFS_VAL);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      piv_q <= '0;
      en_q  <= 1'b0;
      ien_q <= 1'b0;
    end else if (wr_mode) begin
      piv_q <= wdata_i[PIV_W-1:0];
      en_q  <= wdata_i[EN_BIT];
      ien_q <= wdata_i[IEN_BIT];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      case (addr_i)
        OFS_MODE: begin
          rdata_o[PIV_W-1:0] = piv_q;
          rdata_o[EN_BIT]    = en_q;
          rdata_o[IEN_BIT]   = ien_q;
        end
        OFS_STAT: rdata_o[0] = sts_i;
        OFS_VAL, OFS_IMG: rdata_o = {picnt_i, cpiv_i};
        default: rdata_o = '0;
      endcase
    end
  end

  assign piv_o = piv_q;
  assign en_o  = en_q;
  assign ien_o = ien_q;
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int PIV_W  = pit_pkg::PIV_W,
  parameter int CNT_W  = pit_pkg::CNT_W,
  parameter int PRE_W  = pit_pkg::PRE_W,
  parameter int DATA_W = pit_pkg::DATA_W,
  parameter int ADDR_W = pit_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [PIV_W-1:0] piv_w, cpiv_w;
  logic [CNT_W-1:0] picnt_w;
  logic             en_w, ien_w, sts_w, ack_w, tick_w, run_w;

  // keeps running after disable until the period closes at zero
  assign run_w = en_w || (cpiv_w != '0);

  pit_bus_regs #(.PIV_W(PIV_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .cpiv_i(cpiv_w), .picnt_i(picnt_w), .sts_i(sts_w),
    .rdata_o, .piv_o(piv_w), .en_o(en_w), .ien_o(ien_w), .ack_o(ack_w)
  );

  pit_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i, .rst_ni, .run_i(run_w), .tick_o(tick_w)
  );

  pit_counter #(.PIV_W(PIV_W), .CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick_w), .ack_i(ack_w), .piv_i(piv_w),
    .cpiv_o(cpiv_w), .picnt_o(picnt_w), .sts_o(sts_w)
  );

  assign irq_o = sts_w & ien_w;
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk
  import pit_pkg::*;
#(
  parameter int PIV_W  = pit_pkg::PIV_W,
  parameter int CNT_W  = pit_pkg::CNT_W,
  parameter int ADDR_W = pit_pkg::ADDR_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              irq_o,
  input logic [PIV_W-1:0]  cpiv,
  input logic [CNT_W-1:0]  picnt,
  input logic              sts,
  input logic              en
);
  logic rd_val, rd_img, wr_mode;
  assign rd_val  = req_i && !we_i && (addr_i == OFS_VAL);
  assign rd_img  = req_i && !we_i && (addr_i == OFS_IMG);
  assign wr_mode = req_i && we_i && (addr_i == OFS_MODE);

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpiv != $past(cpiv)) |-> (cpiv == PIV_W'($past(cpiv) + 1'b1) || cpiv == '0));

  p_wrap_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpiv != '0) |=> (cpiv != '0 || sts));

  p_ack_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_val |=> (picnt <= CNT_W'(1)));

  p_image_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_img && sts) |=> sts);

  p_irq_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !rd_val && !wr_mode) |=> irq_o);

  p_rest_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && cpiv == '0) |=> (cpiv == '0));
endmodule

bind pit_timer pit_timer_chk #(.PIV_W(PIV_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .irq_o,
  .cpiv(cpiv_w), .picnt(picnt_w), .sts(sts_w), .en(en_w)
);

// File: tb/tb_pit_timer.sv
module tb_pit_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pit_timer dut (.clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
                 .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  // behavioural reference
  int m_piv, m_cpiv, m_picnt, m_pre;
  bit m_en, m_ien, m_sts;
  bit t_run, t_tick, t_wrap;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_piv = 0; m_cpiv = 0; m_picnt = 0; m_pre = 0;
      m_en = 0; m_ien = 0; m_sts = 0;
    end else begin
      t_run = m_en || (m_cpiv != 0);
      t_tick = 0;
      if (t_run) begin
        if (m_pre == 15) begin t_tick = 1; m_pre = 0; end
        else m_pre = m_pre + 1;
      end else m_pre = 0;
      t_wrap = t_tick && (m_cpiv == m_piv);
      if (req && !we && addr == 4'h8) begin m_sts = 0; m_picnt = 0; end
      if (t_tick) begin
        if (t_wrap) begin m_cpiv = 0; m_picnt = (m_picnt + 1) % 4096; m_sts = 1; end
        else m_cpiv = m_cpiv + 1;
      end
      if (req && we && addr == 4'h0) begin
        m_piv = int'(wdata[19:0]); m_en = wdata[24]; m_ien = wdata[25];
      end
    end
  end

  function automatic logic [31:0] exp_rd(logic [3:0] a);
    case (a)
      4'h0: return {6'b0, m_ien, m_en, 4'b0, 20'(m_piv)};
      4'h4: return {31'b0, m_sts};
      4'h8, 4'hC: return {12'(m_picnt), 20'(m_cpiv)};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // R8: level interrupt compared every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      #3;
      chk("R8 irq", {31'b0, irq}, {31'b0, m_sts & m_ien});
    end
  end

  task automatic rd(logic [3:0] a, string tag);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #2 chk(tag, rdata, exp_rd(a));
    @(posedge clk); #1;
    req = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 0; we = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 irq at reset", {31'b0, irq}, 32'h0);
    rd(4'hC, "R1 image at reset");
    rd(4'h0, "R1 mode at reset");
    idle(40);
    rd(4'hC, "R1 counter idle");

    wr(4'h0, 32'h0300_0003);
    rd(4'h0, "R2 mode readback");
    for (int i = 0; i < 70; i++) rd(4'hC, "R3 R4 R6 image poll");
    for (int i = 0; i < 20; i++) rd(4'h4, "R7 status poll");
    rd(4'h8, "R5 value read");
    rd(4'h4, "R5 status after ack");
    rd(4'hC, "R5 count after ack");
    for (int i = 0; i < 150; i++) rd(4'h8, "R5 dense ack");

    wr(4'h0, 32'h0100_0003);
    idle(200);
    rd(4'h4, "R8 masked status");
    rd(4'hC, "R8 still counting");

    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'h8, 32'hFFFF_FFFF);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'h0, "R11 mode untouched");
    rd(4'h4, "R11 status untouched");
    rd(4'hC, "R11 count untouched");

    rd(4'h8, "R9 clear");
    wr(4'h0, 32'h0300_0009);
    idle(40);
    wr(4'h0, 32'h0200_0009);
    for (int i = 0; i < 220; i++) rd(4'hC, "R9 drain poll");
    chk("R9 rests at zero", {12'b0, rdata[19:0]}, 32'h0);

    wr(4'h0, 32'h0300_0000);
    rd(4'h8, "R10 clear");
    idle(4096 * 16 + 40);
    rd(4'hC, "R10 count wrap");
    rd(4'h8, "R10 ack after wrap");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule